// File: doc/BRIEF.md
# Self-Timed Fall-Through Word Stack

This block is the storage core between an input staging register and an output staging register. It holds up to 62 words of 4 bits in a chain of locations, each with its own occupied flag. There are no read or write pointers: a word written at the top moves down one location per clock on its own and stops only when the location below it is still occupied and is not being vacated in the same cycle. The word in the lowest location is offered to the output side, which takes it with a ready signal.

The upper side is a valid/ready stream. The writer holds `in_valid` and `in_data` until it sees `in_ready`. A transfer happens on every rising clock edge where both are high. `in_ready` is high only while the top location is empty. The lower side is also a valid/ready stream. `out_valid` shows that the lowest location is occupied. The consumer may hold `out_ready` low for as long as it likes; the word and its valid flag then stay where they are. The stack fills from the bottom up behind the held word.

An asynchronous active-low reset clears the occupied flags only. The stored data bits keep their values, and `out_data` always shows the contents of the lowest location, whether or not it is flagged occupied.

Top module: `fall_stack`

## Requirements
- R1: With the output held back, the stack accepts exactly DEPTH (62) words and then holds `in_ready` low.
- R2: `in_ready` is high exactly when the top location is empty. A word is taken on a rising edge with `in_valid` and `in_ready` both high. Data offered while `in_ready` is low is not stored.
- R3: A word moves down at most one location per clock. It stops when the location below is occupied and is not emptying in the same cycle. A location can take a new word on the same edge that its old word moves on.
- R4: In an empty stack, a word accepted on edge n is flagged at the output after edge n+DEPTH-1.
- R5: `out_valid` is high exactly when the lowest location is occupied. While `out_ready` is low, `out_valid` and `out_data` stay unchanged.
- R6: A rising edge with `out_valid` and `out_ready` high removes the bottom word. The word just above it moves into the bottom location on that same edge, so a full stack drains with `out_valid` high for DEPTH consecutive cycles.
- R7: Words leave in the order they were accepted, under any mix of writes, stalls and reads in the same cycles.
- R8: `full` is high exactly when the top location is occupied. `empty` is high exactly when no location is occupied.
- R9: Asserting `rst_n` low (asynchronous) clears every occupied flag at once: `out_valid`=0, `empty`=1, `full`=0, `in_ready`=1. The stored bits are not cleared, so `out_data` keeps the word that was in the lowest location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the occupied flags |
| in_valid | input | 1 | Writer offers a word |
| in_data | input | 4 | Word offered by the writer |
| in_ready | output | 1 | Top location empty; the offered word is taken this edge |
| out_valid | output | 1 | Lowest location holds a word |
| out_data | output | 4 | Contents of the lowest location |
| out_ready | input | 1 | Consumer takes the bottom word this edge |
| full | output | 1 | Top location occupied |
| empty | output | 1 | No location occupied |

## Verification
A write at the top and a read at the bottom can land on the same edge. Within the chain, a location can also lose its word and take the word above it on that edge. The bench provokes both. It drains a full stack with `out_ready` held high, which makes every location hand down and refill on each edge. It also runs thousands of cycles with random `in_valid` and `out_ready`, so writes, stalls and reads overlap in every combination. Both cases are judged on every clock against a behavioural model that keeps a queue of words and their positions. It checks the handshake flags, `full`, `empty`, the order of the data, and the gapless run of `out_valid` during a drain.

// File: rtl/fall_stack_pkg.sv
package fall_stack_pkg;
  localparam int unsigned WORD_W_DEF = 4;
  localparam int unsigned DEPTH_DEF  = 62;

  function automatic int unsigned occ_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/fall_stack_ripple.sv
module fall_stack_ripple #(
  parameter int unsigned DEPTH = 62
) (
  input  logic [DEPTH-1:0] occ,
  input  logic             drain,
  output logic [DEPTH-1:0] hop
);
  // Bottom location leaves on a read; every other location leaves when the
  // slot below is empty or is itself leaving this cycle.
  always_comb begin
    hop = '0;
    hop[DEPTH-1] = occ[DEPTH-1] & drain;
    for (int i = int'(DEPTH) - 2; i >= 0; i--) begin
      hop[i] = occ[i] & (~occ[i+1] | hop[i+1]);
    end
  end
endmodule

// File: rtl/fall_stack_cell.sv
module fall_stack_cell #(
  parameter int unsigned WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill,
  input  logic [WORD_W-1:0] fill_word,
  input  logic              leave,
  output logic              occ_q,
  output logic [WORD_W-1:0] word_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= 1'b0;
    end else if (fill) begin
      occ_q <= 1'b1;
    end else if (leave) begin
      occ_q <= 1'b0;
    end
  end

  // Data bits carry no reset.
  always_ff @(posedge clk) begin
    if (fill) begin
      word_q <= fill_word;
    end
  end

  // R3: a stalled word neither moves nor changes
  a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q && !leave) |=> (occ_q && $stable(word_q)));
endmodule

// File: rtl/fall_stack_status.sv
module fall_stack_status #(
  parameter int unsigned DEPTH = 62,
  parameter int unsigned CNT_W = 6
) (
  input  logic [DEPTH-1:0] occ,
  output logic             top_busy,
  output logic             none_busy,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    top_busy  = occ[0];
    none_busy = ~|occ;
    count     = '0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      count = count + CNT_W'(occ[i]);
    end
  end
endmodule

// File: rtl/fall_stack.sv
module fall_stack
  import fall_stack_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned DEPTH  = DEPTH_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  input  logic              out_ready,
  output logic              full,
  output logic              empty
);
  localparam int unsigned CNT_W = occ_width(DEPTH);

  logic [DEPTH-1:0]  occ;
  logic [DEPTH-1:0]  hop;
  logic [WORD_W-1:0] word [DEPTH];
  logic              push;
  logic              pop;
  logic [CNT_W-1:0]  count;
  logic              top_busy;
  logic              none_busy;

  assign in_ready  = ~top_busy;
  assign push      = in_valid & in_ready;
  assign out_valid = occ[DEPTH-1];
  assign out_data  = word[DEPTH-1];
  assign pop       = out_valid & out_ready;
  assign full      = top_busy;
  assign empty     = none_busy;

  fall_stack_ripple #(.DEPTH(DEPTH)) u_ripple (
    .occ   (occ),
    .drain (out_ready),
    .hop   (hop)
  );

  generate
    for (genvar g = 0; g < int'(DEPTH); g++) begin : g_loc
      if (g == 0) begin : g_top
        fall_stack_cell #(.WORD_W(WORD_W)) u_cell (
          .clk       (clk),
          .rst_n     (rst_n),
          .fill      (push),
          .fill_word (in_data),
          .leave     (hop[g]),
          .occ_q     (occ[g]),
          .word_q    (word[g])
        );
      end else begin : g_low
        fall_stack_cell #(.WORD_W(WORD_W)) u_cell (
          .clk       (clk),
          .rst_n     (rst_n),
          .fill      (hop[g-1]),
          .fill_word (word[g-1]),
          .leave     (hop[g]),
          .occ_q     (occ[g]),
          .word_q    (word[g])
        );
      end
    end
  endgenerate

  fall_stack_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_status (
    .occ       (occ),
    .top_busy  (top_busy),
    .none_busy (none_busy),
    .count     (count)
  );

  // R7: occupancy changes only by one accepted write and one read per edge
  a_r7_conserve: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) == int'($past(count)) + int'($past(push)) - int'($past(pop)));

  // R5: a held-back output word stays put
  a_r5_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2: an accepted word leaves the stack non-empty
  a_r2_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !empty);

  // R8: an empty stack shows neither a full top nor an output word
  a_r8_empty_flags: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (!full && !out_valid));

  // R1: a full stack refuses writes
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !in_ready);
endmodule

// File: tb/test_fall_stack.sv
module test_fall_stack;
  localparam int DEPTH = 62;
  localparam int W     = 4;
  localparam time CLK_P = 20ns;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] in_data;
  logic         in_ready;
  logic         out_valid;
  logic [W-1:0] out_data;
  logic         out_ready;
  logic         full;
  logic         empty;

  int checks = 0;
  int errors = 0;
  bit chk_on = 0;
  bit done   = 0;

  int mdat[$];
  int mpos[$];
  int mbot = -1;

  always #(CLK_P/2) clk = ~clk;

  fall_stack i_fall_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .full      (full),
    .empty     (empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: queue of words with their positions (0 = top).
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdat.delete();
      mpos.delete();
    end else begin
      bit pu;
      pu = in_valid && (mpos.size() == 0 || mpos[mpos.size()-1] != 0);
      if (out_ready && mpos.size() > 0 && mpos[0] == DEPTH-1) begin
        void'(mdat.pop_front());
        void'(mpos.pop_front());
      end
      for (int k = 0; k < mpos.size(); k++) begin
        int lim;
        lim = (k == 0) ? DEPTH-1 : mpos[k-1] - 1;
        if (mpos[k] < lim) begin
          mpos[k] = mpos[k] + 1;
          if (mpos[k] == DEPTH-1) mbot = mdat[k];
        end
      end
      if (pu) begin
        mdat.push_back(int'(in_data));
        mpos.push_back(0);
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      bit eov, eir, eem;
      eov = mpos.size() > 0 && mpos[0] == DEPTH-1;
      eir = !(mpos.size() > 0 && mpos[mpos.size()-1] == 0);
      eem = mpos.size() == 0;
      chk(out_valid == eov, "R5 out_valid", out_valid, eov);
      chk(in_ready == eir, "R2 in_ready", in_ready, eir);
      chk(full == !eir, "R8 full", full, !eir);
      chk(empty == eem, "R8 empty", empty, eem);
      if (eov) chk(int'(out_data) == mdat[0], "R7 order", out_data, mdat[0]);
      if (mbot >= 0) chk(int'(out_data) == mbot, "R3 bottom word", out_data, mbot);
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int acc, seen, n, saved;
    bit gap;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(out_valid == 1'b0, "R9 reset out_valid", out_valid, 0);
    chk(empty == 1'b1, "R9 reset empty", empty, 1);
    chk(full == 1'b0, "R9 reset full", full, 0);
    chk(in_ready == 1'b1, "R9 reset in_ready", in_ready, 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    chk_on = 1;

    // R1 fill with output held back
    acc = 0;
    in_valid = 1'b1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (in_ready) acc++;
      @(posedge clk); #1;
      in_data = W'(acc);
    end
    chk(acc == DEPTH, "R1 words accepted", acc, DEPTH);
    chk(full == 1'b1 && in_ready == 1'b0, "R1 full refuses", in_ready, 0);

    // R2: offered data while full must be ignored
    in_data = 4'hA;
    repeat (10) @(posedge clk);
    #1;
    in_valid = 1'b0;

    // R6 gapless drain, R7 order
    out_ready = 1'b1;
    seen = 0; gap = 0;
    for (int k = 0; k < DEPTH + 6; k++) begin
      @(negedge clk);
      if (out_valid) begin
        chk(int'(out_data) == (seen % 16), "R7 drain order", out_data, seen % 16);
        if (k != seen) gap = 1;
        seen++;
      end
      @(posedge clk);
    end
    chk(seen == DEPTH, "R2 ignored writes absent", seen, DEPTH);
    chk(gap == 1'b0, "R6 gapless drain", gap, 0);
    #1;

    // R3/R7 random overlap of writes, stalls and reads
    for (int k = 0; k < 4000; k++) begin
      in_valid  = 1'($urandom_range(0, 1));
      out_ready = ($urandom_range(0, 3) != 0) ? (k % 700 < 350) : 1'b0;
      in_data   = W'($urandom_range(0, 15));
      @(posedge clk); #1;
    end

    // R9: reset keeps stored bits
    in_valid = 1'b1; in_data = 4'h9; out_ready = 1'b0;
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (DEPTH + 5) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b1, "R5 bottom held", out_valid, 1);
    saved = int'(out_data);
    @(posedge clk); #1;
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 out_valid cleared", out_valid, 0);
    chk(empty == 1'b1, "R9 empty after reset", empty, 1);
    chk(in_ready == 1'b1 && full == 1'b0, "R9 top free", in_ready, 1);
    chk(int'(out_data) == saved, "R9 data kept", out_data, saved);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R4 fall-through latency
    in_valid = 1'b1; in_data = 4'h5;
    @(posedge clk); #1;
    in_valid = 1'b0;
    n = 0;
    @(negedge clk);
    while (!out_valid && n < 4 * DEPTH) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    chk(n == DEPTH - 1, "R4 latency", n, DEPTH - 1);
    chk(int'(out_data) == 5, "R4 word", out_data, 5);
    @(posedge clk); #1;
    out_ready = 1'b1;
    @(posedge clk); #1;
    out_ready = 1'b0;
    @(negedge clk);
    chk(empty == 1'b1 && out_valid == 1'b0, "R6 last word removed", empty, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule